// File: doc/BRIEF.md
# Wavefront Tile Stage Scheduler

This block controls a tile accelerator split into three concurrent stages: an input fetch stage, an execute stage and a result drain stage. The host loads per-face base addresses, per-face tile strides and per-face segment lengths, then pulses `start` with the number of tiles in one wavefront of mutually independent tiles. The scheduler walks the tile list in order. It fetches the input faces of a later tile while an earlier one executes, and it drains the results of an earlier tile while a later one executes. It raises `done` once the last word of the last tile has been written.

Each tile's input and each tile's output consist of `NF` contiguous segments (3 for two-dimensional data), one per face. A segment starts at `base + tx*x_stride + ty*y_stride` for that face, where `(tx, ty)` is the tile coordinate. The host supplies the coordinate through an indexed lookup: the block presents a tile index and reads back the coordinate. Every segment goes out as address/length burst commands over a 32-bit data bus. No burst is longer than 256 beats, and no burst crosses a 4096-byte address boundary. The execute stage is external. The block pulses `exec_go` with a tile index and waits for `exec_done`. The number of tiles in flight is limited by `IN_SLOTS` input buffers and `OUT_SLOTS` output buffers.

Top module: `tile_wave_sched`

## Requirements
- R1: After reset, `busy`, `done`, `rd_cmd_valid`, `wr_cmd_valid` and `exec_go` are all 0.
- R2: Input commands start segments at `in_base[f] + tx*x_stride[f] + ty*y_stride[f]` (face f occupies bits f*AW upward). Segments are issued in face order 0,1,2 within a tile, and tiles are issued in list order 0..num_tiles-1.
- R3: Every command has a length (`*_cmd_len`, in 32-bit beats) from 1 to 256, and satisfies `(addr mod 4096) + 4*len <= 4096`.
- R4: The bursts of one segment are contiguous: each burst starts at the previous address plus 4*len. Their lengths add up to the face length, which is at least 1. A command that is not accepted keeps its address and length until it is accepted.
- R5: The input fetch of a tile may overlap the execution of an earlier tile. At any time while a fetch command is pending, the tiles from the oldest tile not yet finished executing up to the tile being fetched number at most `IN_SLOTS`.
- R6: `exec_go` is a one-cycle pulse. It carries tile indices 0,1,2,… in order. Each pulse comes only after every input beat of that tile has been received, and only while fewer than `OUT_SLOTS` executed-or-executing tiles are waiting to be written.
- R7: Output commands start segments at `out_base[f] + tx*x_stride[f] + ty*y_stride[f]`, with face lengths `out_len[f]`. They are issued only for a tile whose `exec_done` has already been received.
- R8: `busy` is high from the cycle after an accepted `start` until `done` rises. `done` rises only after the final write beat of the last tile, and it stays high until the next `start`.
- R9: A `start` pulse while `busy` is high has no effect on the running wavefront.
- R10: A `start` with `num_tiles` = 0 sets `done` in the next cycle and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one wavefront |
| num_tiles | input | TW | Tiles in the wavefront |
| busy | output | 1 | Wavefront running |
| done | output | 1 | Wavefront finished |
| in_base | input | NF*AW | Per-face input base address |
| out_base | input | NF*AW | Per-face output base address |
| x_stride | input | NF*AW | Per-face address step per tile x |
| y_stride | input | NF*AW | Per-face address step per tile y |
| in_len | input | NF*LW | Per-face input segment length, beats |
| out_len | input | NF*LW | Per-face output segment length, beats |
| rd_tile | output | TW | Tile index for fetch coordinate lookup |
| rd_tx | input | CW | x coordinate of `rd_tile` |
| rd_ty | input | CW | y coordinate of `rd_tile` |
| rd_cmd_valid | output | 1 | Read burst command valid |
| rd_cmd_ready | input | 1 | Read burst command accepted |
| rd_cmd_addr | output | AW | Read burst byte address |
| rd_cmd_len | output | LW | Read burst length, beats |
| rd_beat | input | 1 | One read data beat delivered |
| exec_go | output | 1 | Launch execution of `exec_tile` |
| exec_tile | output | TW | Tile being executed |
| exec_done | input | 1 | Execution of `exec_tile` finished |
| wr_tile | output | TW | Tile index for drain coordinate lookup |
| wr_tx | input | CW | x coordinate of `wr_tile` |
| wr_ty | input | CW | y coordinate of `wr_tile` |
| wr_cmd_valid | output | 1 | Write burst command valid |
| wr_cmd_ready | input | 1 | Write burst command accepted |
| wr_cmd_addr | output | AW | Write burst byte address |
| wr_cmd_len | output | LW | Write burst length, beats |
| wr_beat | input | 1 | One write data beat consumed |

## Verification
The assertions check the following on every cycle: burst length limits and boundary safety, command stability under back-pressure, the input-slot bound, the single-cycle launch pulse, and the ordering of fetch, execute and drain tile indices against each other. Only the bench's scenarios can show the rest. These are the exact address and length sequence of each split segment, the fact that a later fetch really overlaps an earlier execution, the placement of `done` after the last write beat, that a start during a run is ignored, and the empty-wavefront case.

// File: rtl/tile_wave_sched.sv
module tile_wave_sched #(
  parameter int AW = 32,
  parameter int CW = 12,
  parameter int LW = 16,
  parameter int TW = 8,
  parameter int NF = 3,
  parameter int IN_SLOTS = 2,
  parameter int OUT_SLOTS = 2,
  parameter int MAX_BEATS = 256,
  parameter int BOUND = 4096
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TW-1:0]   num_tiles,
  output logic            busy,
  output logic            done,
  input  logic [NF*AW-1:0] in_base,
  input  logic [NF*AW-1:0] out_base,
  input  logic [NF*AW-1:0] x_stride,
  input  logic [NF*AW-1:0] y_stride,
  input  logic [NF*LW-1:0] in_len,
  input  logic [NF*LW-1:0] out_len,
  output logic [TW-1:0]   rd_tile,
  input  logic [CW-1:0]   rd_tx,
  input  logic [CW-1:0]   rd_ty,
  output logic            rd_cmd_valid,
  input  logic            rd_cmd_ready,
  output logic [AW-1:0]   rd_cmd_addr,
  output logic [LW-1:0]   rd_cmd_len,
  input  logic            rd_beat,
  output logic            exec_go,
  output logic [TW-1:0]   exec_tile,
  input  logic            exec_done,
  output logic [TW-1:0]   wr_tile,
  input  logic [CW-1:0]   wr_tx,
  input  logic [CW-1:0]   wr_ty,
  output logic            wr_cmd_valid,
  input  logic            wr_cmd_ready,
  output logic [AW-1:0]   wr_cmd_addr,
  output logic [LW-1:0]   wr_cmd_len,
  input  logic            wr_beat
);
  localparam int FI = (NF > 1) ? $clog2(NF) : 1;
  localparam int PW = LW + $clog2(NF) + 1;

  function automatic logic [AW-1:0] seg(input logic [NF*AW-1:0] b, input int f,
                                        input logic [CW-1:0] tx, input logic [CW-1:0] ty);
    return b[f*AW +: AW] + x_stride[f*AW +: AW] * AW'(tx) + y_stride[f*AW +: AW] * AW'(ty);
  endfunction

  function automatic logic [LW-1:0] burst(input logic [AW-1:0] a, input logic [LW-1:0] rem);
    logic [AW-1:0] room, r;
    room = (AW'(BOUND) - (a & AW'(BOUND - 1))) >> 2;
    r = AW'(rem);
    if (r > AW'(MAX_BEATS)) r = AW'(MAX_BEATS);
    if (r > room) r = room;
    return r[LW-1:0];
  endfunction

  logic run, done_q, go_q, ex_busy;
  logic [TW-1:0] ntl, ex_n, in_used, in_rdy, out_used, out_rdy;
  logic rd_on, rd_wait, wr_on, wr_wait;
  logic [FI-1:0] rd_f, wr_f;
  logic [AW-1:0] rd_a, wr_a;
  logic [LW-1:0] rd_rem, wr_rem;
  logic [PW-1:0] rd_pend, wr_pend;
  logic [TW-1:0] rd_n, wr_n;

  assign busy = run;
  assign done = done_q;
  assign exec_go = go_q;
  assign exec_tile = ex_n;
  assign rd_tile = rd_n;
  assign wr_tile = wr_n;
  assign rd_cmd_valid = rd_on;
  assign rd_cmd_addr = rd_a;
  assign rd_cmd_len = burst(rd_a, rd_rem);
  assign wr_cmd_valid = wr_on;
  assign wr_cmd_addr = wr_a;
  assign wr_cmd_len = burst(wr_a, wr_rem);

  wire rd_acc  = rd_on & rd_cmd_ready;
  wire rd_fin  = rd_wait & (rd_pend == '0);
  wire rd_go   = run & ~rd_on & ~rd_wait & (rd_n < ntl) & (in_used < TW'(IN_SLOTS));
  wire ex_go   = run & ~ex_busy & (in_rdy != '0) & (out_used < TW'(OUT_SLOTS));
  wire ex_fin  = ex_busy & exec_done;
  wire wr_acc  = wr_on & wr_cmd_ready;
  wire wr_fin  = wr_wait & (wr_pend == '0);
  wire wr_go   = run & ~wr_on & ~wr_wait & (out_rdy != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; done_q <= 1'b0; go_q <= 1'b0; ex_busy <= 1'b0;
      ntl <= '0; ex_n <= '0; in_used <= '0; in_rdy <= '0; out_used <= '0; out_rdy <= '0;
      rd_on <= 1'b0; rd_wait <= 1'b0; rd_f <= '0; rd_a <= '0; rd_rem <= '0; rd_pend <= '0; rd_n <= '0;
      wr_on <= 1'b0; wr_wait <= 1'b0; wr_f <= '0; wr_a <= '0; wr_rem <= '0; wr_pend <= '0; wr_n <= '0;
    end else if (start && !run) begin
      run <= (num_tiles != '0); done_q <= (num_tiles == '0); go_q <= 1'b0; ex_busy <= 1'b0;
      ntl <= num_tiles; ex_n <= '0; in_used <= '0; in_rdy <= '0; out_used <= '0; out_rdy <= '0;
      rd_on <= 1'b0; rd_wait <= 1'b0; rd_pend <= '0; rd_n <= '0;
      wr_on <= 1'b0; wr_wait <= 1'b0; wr_pend <= '0; wr_n <= '0;
    end else begin
      go_q <= ex_go;

      if (rd_go) begin
        rd_on <= 1'b1; rd_f <= '0;
        rd_a <= seg(in_base, 0, rd_tx, rd_ty); rd_rem <= in_len[0 +: LW];
      end else if (rd_acc) begin
        if (rd_rem == rd_cmd_len) begin
          if (rd_f == FI'(NF - 1)) begin
            rd_on <= 1'b0; rd_wait <= 1'b1;
          end else begin
            rd_f <= rd_f + 1'b1;
            rd_a <= seg(in_base, int'(rd_f) + 1, rd_tx, rd_ty);
            rd_rem <= in_len[(int'(rd_f) + 1)*LW +: LW];
          end
        end else begin
          rd_a <= rd_a + (AW'(rd_cmd_len) << 2);
          rd_rem <= rd_rem - rd_cmd_len;
        end
      end
      if (rd_fin) begin rd_wait <= 1'b0; rd_n <= rd_n + 1'b1; end
      rd_pend <= rd_pend + (rd_acc ? PW'(rd_cmd_len) : '0) - PW'(rd_beat);

      if (ex_go) ex_busy <= 1'b1;
      if (ex_fin) begin ex_busy <= 1'b0; ex_n <= ex_n + 1'b1; end

      if (wr_go) begin
        wr_on <= 1'b1; wr_f <= '0;
        wr_a <= seg(out_base, 0, wr_tx, wr_ty); wr_rem <= out_len[0 +: LW];
      end else if (wr_acc) begin
        if (wr_rem == wr_cmd_len) begin
          if (wr_f == FI'(NF - 1)) begin
            wr_on <= 1'b0; wr_wait <= 1'b1;
          end else begin
            wr_f <= wr_f + 1'b1;
            wr_a <= seg(out_base, int'(wr_f) + 1, wr_tx, wr_ty);
            wr_rem <= out_len[(int'(wr_f) + 1)*LW +: LW];
          end
        end else begin
          wr_a <= wr_a + (AW'(wr_cmd_len) << 2);
          wr_rem <= wr_rem - wr_cmd_len;
        end
      end
      if (wr_fin) begin
        wr_wait <= 1'b0; wr_n <= wr_n + 1'b1;
        if (wr_n == ntl - 1'b1) begin run <= 1'b0; done_q <= 1'b1; end
      end
      wr_pend <= wr_pend + (wr_acc ? PW'(wr_cmd_len) : '0) - PW'(wr_beat);

      in_used  <= in_used  + TW'(rd_go)  - TW'(ex_fin);
      in_rdy   <= in_rdy   + TW'(rd_fin) - TW'(ex_go);
      out_used <= out_used + TW'(ex_go)  - TW'(wr_fin);
      out_rdy  <= out_rdy  + TW'(ex_fin) - TW'(wr_go);
    end
  end
endmodule

// File: rtl/tile_wave_sched_chk.sv
module tile_wave_sched_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int TW = 8,
  parameter int IN_SLOTS = 2,
  parameter int MAX_BEATS = 256,
  parameter int BOUND = 4096
)(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rd_cmd_valid,
  input logic          rd_cmd_ready,
  input logic [AW-1:0] rd_cmd_addr,
  input logic [LW-1:0] rd_cmd_len,
  input logic [TW-1:0] rd_tile,
  input logic          wr_cmd_valid,
  input logic          wr_cmd_ready,
  input logic [AW-1:0] wr_cmd_addr,
  input logic [LW-1:0] wr_cmd_len,
  input logic [TW-1:0] wr_tile,
  input logic          exec_go,
  input logic [TW-1:0] exec_tile
);
  AST_RD_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> (rd_cmd_len != '0) && (int'(rd_cmd_len) <= MAX_BEATS)); // R3
  AST_WR_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> (wr_cmd_len != '0) && (int'(wr_cmd_len) <= MAX_BEATS)); // R3
  AST_RD_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> (rd_cmd_addr % AW'(BOUND)) + (AW'(rd_cmd_len) << 2) <= AW'(BOUND)); // R3
  AST_WR_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> (wr_cmd_addr % AW'(BOUND)) + (AW'(wr_cmd_len) << 2) <= AW'(BOUND)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid && !rd_cmd_ready |=> rd_cmd_valid && $stable(rd_cmd_addr) && $stable(rd_cmd_len)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid && !wr_cmd_ready |=> wr_cmd_valid && $stable(wr_cmd_addr) && $stable(wr_cmd_len)); // R4
  AST_IN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_valid |-> (int'(rd_tile) - int'(exec_tile) + 1) <= IN_SLOTS); // R5
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !exec_go); // R6
  AST_GO_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> exec_tile < rd_tile); // R6
  AST_DRAIN_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_valid |-> wr_tile < exec_tile); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_cmd_valid && !wr_cmd_valid && !exec_go); // R8
endmodule

bind tile_wave_sched tile_wave_sched_chk #(
  .AW(AW), .LW(LW), .TW(TW), .IN_SLOTS(IN_SLOTS), .MAX_BEATS(MAX_BEATS), .BOUND(BOUND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
  .rd_cmd_len(rd_cmd_len), .rd_tile(rd_tile),
  .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr),
  .wr_cmd_len(wr_cmd_len), .wr_tile(wr_tile),
  .exec_go(exec_go), .exec_tile(exec_tile)
);

// File: tb/sim_tile_wave_sched.sv
`timescale 1ns/1ps
module sim_tile_wave_sched;
  localparam int AW = 32, CW = 12, LW = 16, TW = 8, NF = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [TW-1:0] num_tiles = '0;
  logic busy, done;
  logic [AW-1:0] ib [NF], ob [NF], xs [NF], ys [NF];
  logic [LW-1:0] il [NF], ol [NF];
  logic [CW-1:0] tab_x [16], tab_y [16];
  logic [NF*AW-1:0] in_base, out_base, x_stride, y_stride;
  logic [NF*LW-1:0] in_len, out_len;
  logic [TW-1:0] rd_tile, wr_tile, exec_tile;
  logic [CW-1:0] rd_tx, rd_ty, wr_tx, wr_ty;
  logic rd_cmd_valid, rd_cmd_ready = 1'b1, rd_beat = 1'b0;
  logic wr_cmd_valid, wr_cmd_ready = 1'b1, wr_beat = 1'b0;
  logic [AW-1:0] rd_cmd_addr, wr_cmd_addr;
  logic [LW-1:0] rd_cmd_len, wr_cmd_len;
  logic exec_go, exec_done = 1'b0;

  assign in_base  = {ib[2], ib[1], ib[0]};
  assign out_base = {ob[2], ob[1], ob[0]};
  assign x_stride = {xs[2], xs[1], xs[0]};
  assign y_stride = {ys[2], ys[1], ys[0]};
  assign in_len   = {il[2], il[1], il[0]};
  assign out_len  = {ol[2], ol[1], ol[0]};
  assign rd_tx = tab_x[rd_tile[3:0]];
  assign rd_ty = tab_y[rd_tile[3:0]];
  assign wr_tx = tab_x[wr_tile[3:0]];
  assign wr_ty = tab_y[wr_tile[3:0]];

  tile_wave_sched u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_tiles(num_tiles), .busy(busy), .done(done),
    .in_base(in_base), .out_base(out_base), .x_stride(x_stride), .y_stride(y_stride),
    .in_len(in_len), .out_len(out_len),
    .rd_tile(rd_tile), .rd_tx(rd_tx), .rd_ty(rd_ty),
    .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
    .rd_cmd_len(rd_cmd_len), .rd_beat(rd_beat),
    .exec_go(exec_go), .exec_tile(exec_tile), .exec_done(exec_done),
    .wr_tile(wr_tile), .wr_tx(wr_tx), .wr_ty(wr_ty),
    .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr),
    .wr_cmd_len(wr_cmd_len), .wr_beat(wr_beat)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [AW-1:0] rl_a [64], wl_a [64], xa [64];
  int rl_l [64], wl_l [64], xl [64];
  int rl_n, wl_n, xn;
  int rd_owed, wr_owed, rd_given, ex_cnt, ex_seen, ex_timer, ex_cur, ex_lat;
  int max_res, r6_viol, r7_viol, last_wr_cyc, done_cyc;
  bit slow, ovl, done_prev;

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_logs();
    rl_n = 0; wl_n = 0; rd_owed = 0; wr_owed = 0; rd_given = 0; ex_cnt = 0; ex_seen = 0;
    ex_timer = 0; max_res = 0; r6_viol = 0; r7_viol = 0; last_wr_cyc = 0; done_cyc = -1;
    ovl = 1'b0;
  endtask

  // Host-side responders: memory beats and external execute stage.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_cmd_valid && rd_cmd_ready) begin
        if (rl_n < 64) begin rl_a[rl_n] = rd_cmd_addr; rl_l[rl_n] = int'(rd_cmd_len); end
        rl_n++;
        rd_owed += int'(rd_cmd_len);
        if (int'(rd_tile) - ex_cnt + 1 > max_res) max_res = int'(rd_tile) - ex_cnt + 1;
        if (rd_tile == 1 && ex_timer > 0 && ex_cur == 0) ovl = 1'b1;
      end
      if (wr_cmd_valid && wr_cmd_ready) begin
        if (wl_n < 64) begin wl_a[wl_n] = wr_cmd_addr; wl_l[wl_n] = int'(wr_cmd_len); end
        wl_n++;
        wr_owed += int'(wr_cmd_len);
        if (int'(wr_tile) >= ex_cnt) r7_viol++;
      end
      if (exec_go) begin
        if (rd_given < (int'(exec_tile) + 1) * (int'(il[0]) + int'(il[1]) + int'(il[2]))) r6_viol++;
        if (int'(exec_tile) != ex_seen) r6_viol++;
        ex_seen++;
      end
      exec_done = 1'b0;
      if (ex_timer > 0) begin
        ex_timer--;
        if (ex_timer == 0) begin exec_done = 1'b1; ex_cnt++; end
      end
      if (exec_go) begin ex_timer = ex_lat; ex_cur = int'(exec_tile); end
      rd_beat = 1'b0;
      if (rd_owed > 0) begin rd_beat = 1'b1; rd_owed--; rd_given++; end
      wr_beat = 1'b0;
      if (wr_owed > 0 && (cyc % 3) != 0) begin wr_beat = 1'b1; wr_owed--; last_wr_cyc = cyc; end
      rd_cmd_ready = slow ? ((cyc % 2) == 0) : 1'b1;
      wr_cmd_ready = slow ? ((cyc % 3) != 1) : 1'b1;
      if (done && !done_prev && done_cyc < 0) done_cyc = cyc;
      done_prev = done;
    end
  end

  task automatic build(input bit wr, input int n);
    xn = 0;
    for (int k = 0; k < n; k++)
      for (int f = 0; f < NF; f++) begin
        logic [AW-1:0] a;
        int rem, b, room;
        a = (wr ? ob[f] : ib[f]) + xs[f] * AW'(tab_x[k]) + ys[f] * AW'(tab_y[k]);
        rem = wr ? int'(ol[f]) : int'(il[f]);
        while (rem > 0) begin
          room = (4096 - int'(a & 32'hFFF)) / 4;
          b = rem;
          if (b > 256) b = 256;
          if (b > room) b = room;
          if (xn < 64) begin xa[xn] = a; xl[xn] = b; end
          xn++;
          a = a + AW'(4 * b);
          rem -= b;
        end
      end
  endtask

  task automatic cmp(input bit wr, input int n, input string tag);
    int cnt;
    build(wr, n);
    cnt = wr ? wl_n : rl_n;
    chk(cnt == xn, {tag, " command count"}, cnt, xn);
    for (int i = 0; i < xn && i < cnt && i < 64; i++) begin
      logic [AW-1:0] ga;
      int gl;
      ga = wr ? wl_a[i] : rl_a[i];
      gl = wr ? wl_l[i] : rl_l[i];
      chk(ga == xa[i], {tag, " address"}, ga, xa[i]);
      chk(gl == xl[i], {tag, " length"}, gl, xl[i]);
      chk(gl >= 1 && gl <= 256 && int'(ga & 32'hFFF) + 4 * gl <= 4096, "R3 burst limits", gl, 256);
    end
  endtask

  task automatic run_wave(input int n, input bit s, input int lat);
    slow = s; ex_lat = lat;
    clear_logs();
    @(negedge clk);
    num_tiles = TW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R8 busy after start", {busy, done}, 2'b10);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R8 done reached", done, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, rd_cmd_valid, wr_cmd_valid, exec_go} == 5'b0, "R1 reset outputs",
        {busy, done, rd_cmd_valid, wr_cmd_valid, exec_go}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, rd_cmd_valid, wr_cmd_valid, exec_go} == 5'b0, "R1 idle after reset",
        {busy, done, rd_cmd_valid, wr_cmd_valid, exec_go}, 0);
  endtask

  task automatic t_basic();
    ib[0] = 32'h1000; ib[1] = 32'h8000; ib[2] = 32'h10000;
    ob[0] = 32'h40000; ob[1] = 32'h48000; ob[2] = 32'h50000;
    xs[0] = 32'h100; xs[1] = 32'h40; xs[2] = 32'h80;
    ys[0] = 32'h2000; ys[1] = 32'h400; ys[2] = 32'h800;
    il[0] = 5; il[1] = 7; il[2] = 3; ol[0] = 4; ol[1] = 4; ol[2] = 4;
    tab_x[0] = 0; tab_y[0] = 0; tab_x[1] = 1; tab_y[1] = 0; tab_x[2] = 2; tab_y[2] = 1;
    run_wave(3, 1'b0, 3);
    cmp(1'b0, 3, "R2 fetch");
    cmp(1'b1, 3, "R7 drain");
    chk(ex_seen == 3 && r6_viol == 0, "R6 launch order and input complete", r6_viol, 0);
    chk(r7_viol == 0, "R7 drain after exec_done", r7_viol, 0);
    chk(done_cyc > last_wr_cyc && wr_owed == 0, "R8 done after last write beat", done_cyc, last_wr_cyc + 1);
  endtask

  task automatic t_split();
    ib[0] = 32'h0FF0; ib[1] = 32'h2000; ib[2] = 32'h3FFC;
    il[0] = 600; il[1] = 300; il[2] = 1;
    ob[0] = 32'h7F00; ol[0] = 70; ol[1] = 2; ol[2] = 2;
    tab_x[0] = 0; tab_y[0] = 0;
    run_wave(1, 1'b1, 2);
    chk(rl_n == 7, "R4 split count 4+2+1", rl_n, 7);
    chk(rl_l[0] == 4 && rl_l[1] == 256 && rl_l[3] == 84, "R3 boundary then cap split", rl_l[3], 84);
    chk(rl_a[1] == 32'h1000 && rl_a[2] == 32'h1400, "R4 contiguous bursts", rl_a[2], 32'h1400);
    cmp(1'b0, 1, "R4 fetch under backpressure");
    cmp(1'b1, 1, "R7 drain under backpressure");
  endtask

  task automatic t_overlap();
    ib[0] = 32'h1000; ib[1] = 32'h8000; ib[2] = 32'h10000;
    il[0] = 8; il[1] = 8; il[2] = 8;
    ob[0] = 32'h40000; ol[0] = 6; ol[1] = 6; ol[2] = 6;
    for (int k = 0; k < 4; k++) begin tab_x[k] = CW'(k); tab_y[k] = CW'(3 - k); end
    run_wave(4, 1'b0, 60);
    chk(ovl == 1'b1, "R5 fetch of tile 1 during execute of tile 0", ovl, 1);
    chk(max_res == 2, "R5 input slot bound reached not exceeded", max_res, 2);
    chk(r6_viol == 0 && ex_seen == 4, "R6 launches with slow execute", ex_seen, 4);
    cmp(1'b0, 4, "R2 fetch four tiles");
    cmp(1'b1, 4, "R7 drain four tiles");
  endtask

  task automatic t_start_busy();
    il[0] = 5; il[1] = 7; il[2] = 3; ol[0] = 4; ol[1] = 4; ol[2] = 4;
    slow = 1'b0; ex_lat = 5;
    clear_logs();
    @(negedge clk);
    num_tiles = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    num_tiles = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 still busy after ignored start", busy, 1);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ex_seen == 3, "R9 wavefront length unchanged", ex_seen, 3);
    cmp(1'b1, 3, "R9 drain of full wavefront");
    repeat (10) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R8 done held while idle", done, 1);
  endtask

  task automatic t_zero();
    clear_logs();
    @(negedge clk);
    num_tiles = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R10 empty wavefront done next cycle", {busy, done}, 2'b01);
    repeat (10) @(negedge clk);
    chk(rl_n == 0 && wl_n == 0 && ex_seen == 0, "R10 no commands", rl_n + wl_n, 0);
  endtask

  initial begin
    for (int f = 0; f < NF; f++) begin
      ib[f] = '0; ob[f] = '0; xs[f] = '0; ys[f] = '0; il[f] = 1; ol[f] = 1;
    end
    for (int k = 0; k < 16; k++) begin tab_x[k] = '0; tab_y[k] = '0; end
    slow = 1'b0; ex_lat = 1; done_prev = 1'b0;
    clear_logs();
    t_reset();
    t_basic();
    t_split();
    t_overlap();
    t_start_busy();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule